// File: doc/BRIEF.md
# One-Hot Decade Phase Sequencer

This block turns one clock into up to ten synchronized phase lines. Exactly one line is high at any time. The high line moves one position forward on every step and returns to line 0 after the last line in use. All lines therefore run at the same frequency, and each lags its lower neighbour by one step, which is 360/MODULUS degrees. A step of 1 µs with MODULUS = 10 gives each line 1 µs high and 9 µs low.

The step rate is derived from the system clock in two ways. An external clock enable `en` gates every step. An internal prescaler then turns every STEP_DIV-th enabled cycle into a step.

The position is held in a 5-bit twisted-ring counter and decoded from adjacent bit pairs. A sequence shorter than ten is made by loading the all-zero pattern after the last wanted position. The phase lines are registered, so every line, including line 0 after a wrap, stays high for exactly one full step.

Top module: `phase_ring_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs after that edge are `phase` = 10'b0000000001 and `cycle_start` = 0, and the step prescaler restarts from zero.
- R2: Out of reset, exactly one bit of `phase` is high in every cycle.
- R3: With `en` held high, the high bit of `phase` moves from bit k to bit k+1 once every STEP_DIV clock cycles. The first move happens on the STEP_DIV-th enabled edge after reset.
- R4: A cycle with `en` low has no effect. `phase` keeps its value and the prescaler count is kept.
- R5: After bit MODULUS-1 the high bit returns to bit 0. Bits MODULUS through 9 are never high.
- R6: With `en` held high, every used phase bit stays high for exactly STEP_DIV cycles per visit. This includes bit 0 after a wrap.
- R7: `cycle_start` is high for exactly one cycle, in the cycle where a step has just moved the high bit to bit 0. It is low in all other cycles.
- R8: If reset and a wrapping step fall on the same edge, reset wins. The result is `phase` = 1 with `cycle_start` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable; gates the prescaler and every step |
| phase | output | 10 | Registered one-hot phase lines |
| cycle_start | output | 1 | One-cycle pulse when the sequence re-enters position 0 |

## Verification
Two events can land on the same edge: the wrap from the last position back to position 0, and a synchronous reset. Both put the sequence at position 0, but only the wrap may raise `cycle_start`. The bench runs its reference model until the next enabled edge would wrap, then asserts reset in that very cycle. It expects `phase` = 1 with `cycle_start` low, followed by normal stepping from a cleared prescaler. A second instance with the full ten-position length and no prescaling runs on the same stimulus, so that wraps also land next to enable gaps.

// File: rtl/phase_ring_seq.sv
module phase_ring_seq #(
  parameter int MODULUS  = 10,
  parameter int STEP_DIV = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  output logic [9:0] phase,
  output logic       cycle_start
);
  localparam int NPH = 10;
  localparam int JW  = 5;
  localparam int CW  = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(STEP_DIV - 1);

  function automatic logic [JW-1:0] pat(input int k);
    if (k < JW) return JW'((1 << k) - 1);
    else        return ~JW'((1 << (k - JW)) - 1);
  endfunction

  localparam logic [JW-1:0] LAST_PAT = pat(MODULUS - 1);

  logic [JW-1:0]  jc, jn;
  logic [CW-1:0]  div_cnt;
  logic [NPH-1:0] dec_n;
  logic           legal, step, load;

  always_comb begin
    legal = 1'b0;
    for (int k = 0; k < NPH; k++)
      if (jc == pat(k)) legal = 1'b1;
  end

  assign step = en && (div_cnt == LAST_CNT);
  assign load = step || !legal;
  assign jn   = (!legal || jc == LAST_PAT) ? '0 : {jc[JW-2:0], ~jc[JW-1]};

  for (genvar k = 0; k < NPH; k++) begin : g_dec
    if (k == 0)       begin : g_z assign dec_n[k] = ~jn[JW-1] & ~jn[0];       end
    else if (k < JW)  begin : g_r assign dec_n[k] =  jn[k-1]  & ~jn[k];       end
    else if (k == JW) begin : g_f assign dec_n[k] =  jn[JW-1] &  jn[0];       end
    else              begin : g_d assign dec_n[k] = ~jn[k-JW-1] & jn[k-JW];   end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      jc          <= '0;
      div_cnt     <= '0;
      phase       <= NPH'(1);
      cycle_start <= 1'b0;
    end else begin
      if (en) div_cnt <= step ? '0 : div_cnt + 1'b1;
      if (load) begin
        jc          <= jn;
        phase       <= dec_n;
        cycle_start <= step && (jn == '0);
      end else begin
        cycle_start <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/phase_ring_seq_chk.sv
module phase_ring_seq_chk #(
  parameter int MODULUS  = 10,
  parameter int STEP_DIV = 1
) (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic [9:0] phase,
  input logic       cycle_start
);
  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= !rst;

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (phase == 10'd1 && !cycle_start));

  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> $countones(phase) == 1);

  p_advance_r3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && phase != $past(phase)) |->
      (phase == ($past(phase) << 1)) || (phase == 10'd1 && $past(phase[MODULUS-1])));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !en) |=> $stable(phase));

  p_range_r5: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (phase >> MODULUS) == 10'd0);

  p_start_pos_r7: assert property (@(posedge clk) disable iff (rst)
    cycle_start |-> phase[0]);

  p_start_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    cycle_start |=> !cycle_start);
endmodule

bind phase_ring_seq phase_ring_seq_chk #(.MODULUS(MODULUS), .STEP_DIV(STEP_DIV)) u_chk (.*);

// File: tb/phase_ring_seq_test.sv
module phase_ring_seq_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, en = 1'b0;
  logic [9:0] ph_a, ph_b;
  logic cs_a, cs_b;

  localparam int MA = 7, DA = 3, MB = 10, DB = 1;

  phase_ring_seq #(.MODULUS(MA), .STEP_DIV(DA)) uut (
    .clk(clk), .rst(rst), .en(en), .phase(ph_a), .cycle_start(cs_a));
  phase_ring_seq #(.MODULUS(MB), .STEP_DIV(DB)) uut_full (
    .clk(clk), .rst(rst), .en(en), .phase(ph_b), .cycle_start(cs_b));

  int nchk = 0, nfail = 0;
  logic [9:0] qpa[$], qpb[$];
  logic       qsa[$], qsb[$];
  string      qtag[$];

  int ia = 0, ca = 0, ib = 0, cb = 0;
  logic sa = 1'b0, sb = 1'b0;

  task automatic model(ref int idx, ref int cnt, ref logic st,
                       input int m, input int d, input logic r, input logic e);
    if (r) begin idx = 0; cnt = 0; st = 1'b0; end
    else if (e && cnt == d - 1) begin
      cnt = 0; idx = (idx == m - 1) ? 0 : idx + 1; st = (idx == 0);
    end else begin
      if (e) cnt++;
      st = 1'b0;
    end
  endtask

  task automatic drive(input logic r, input logic e, input string tag);
    @(negedge clk);
    rst = r; en = e;
    model(ia, ca, sa, MA, DA, r, e);
    model(ib, cb, sb, MB, DB, r, e);
    qpa.push_back(10'd1 << ia); qsa.push_back(sa);
    qpb.push_back(10'd1 << ib); qsb.push_back(sb);
    qtag.push_back(tag);
  endtask

  task automatic chk(input string tag, input string what, input logic [9:0] act, input logic [9:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk); #2;
    if (qtag.size() > 0) begin
      string t;
      t = qtag.pop_front();
      chk(t, "phase(mod7)", ph_a, qpa.pop_front());
      chk(t == "R8" ? "R8" : "R7", "cycle_start(mod7)", {9'd0, cs_a}, {9'd0, qsa.pop_front()});
      chk(t, "phase(mod10)", ph_b, qpb.pop_front());
      chk(t == "R8" ? "R8" : "R7", "cycle_start(mod10)", {9'd0, cs_b}, {9'd0, qsb.pop_front()});
      if (t != "R1") chk("R2", "onehot count(mod7)", 10'($countones(ph_a)), 10'd1);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) drive(1'b1, 1'b0, "R1");
    repeat (40) drive(1'b0, 1'b1, "R3");
    repeat (30) drive(1'b0, 1'b1, "R5");
    repeat (25) drive(1'b0, 1'b1, "R6");
    for (int i = 0; i < 30; i++) drive(1'b0, (i % 3) == 1 || i > 22, "R4");
    repeat (8) drive(1'b0, 1'b0, "R4");
    for (int i = 0; i < 40 && !(ia == MA - 1 && ca == DA - 1); i++) drive(1'b0, 1'b1, "R8");
    drive(1'b1, 1'b1, "R8");
    repeat (5) drive(1'b0, 1'b1, "R8");
    repeat (24) drive(1'b0, 1'b1, "R7");
    repeat (3) @(posedge clk);
    #5;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule